// File: doc/BRIEF.md
# Capture/Compare Event Flag Register

This block is the 16-bit status, interrupt and control register of a two-channel capture/compare timer unit. The timer datapath sends it single-cycle event strobes: a capture strobe and a compare strobe for each of channels A and B. The register holds a sticky event flag. It sets that flag from whichever strobes the programmed operating mode selects. While the flag is set and a non-zero interrupt level is programmed, it raises an interrupt request.

Software reaches the register through a plain synchronous register port. It has a read strobe, a write strobe with a 16-bit write word, and a read word that always shows the current contents. Hardware events can only set the flag. Software clears it in one of two ways. The first is an interlocked sequence: a read that observes the flag at 1, followed by a write with the flag bit at 0. The second is selecting the off mode. Set events always beat a clear, and a set event between the read and the write cancels that clear. There is no streaming data path, so every pin is a plain control or status signal with no back-pressure.

Top module: `ccf_reg`

## Requirements
- R1: After reset the read word is 0x0000 and the interrupt request is low.
- R2: Read word layout is as follows. Bit 15 is the flag. Bits 14:12 are the interrupt level. Bits 11:5 are general storage that reads back as written. Bit 4 always reads 0. Bits 3:0 are the mode. A write updates bits 14:0 (bit 4 excepted) at the clock edge of the write.
- R3: The interrupt request is high exactly while the flag is 1 and the interrupt level is non-zero.
- R4: Mode 4'b0000 is off. In this mode the flag stays 0 whatever the strobes do, and a write selecting 0000 clears the flag at that same edge.
- R5: In modes 4'b0001 (pulse width) and 4'b0011 (input capture), a channel A capture strobe sets the flag and the other strobes do not. The flag reads 1 in the cycle after the strobe.
- R6: In mode 4'b0010 (period measurement), the first channel A capture after reset, or after a write that changes the mode, does not set the flag. Every later one does. A write that leaves the mode unchanged does not re-arm the suppression.
- R7: In mode 4'b0100 only a channel B compare strobe sets the flag. In mode 4'b0101 a channel A or channel B compare strobe sets it.
- R8: In modes 4'b1xxx (output PWM) a channel A compare strobe sets the flag and the other strobes do not.
- R9: In the spare modes 4'b0110 and 4'b0111 no strobe sets the flag, and the flag keeps its value.
- R10: Writing 1 to bit 15 never sets the flag.
- R11: A read strobe while the flag is 1 arms a clear. The next write with bit 15 at 0 then clears the flag. Any write disarms the clear. A write with bit 15 at 0 and no armed read leaves the flag at 1.
- R12: A set event that occurs after the arming read and before the write cancels the clear, and the flag stays 1.
- R13: When a set event and an armed clearing write fall in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write word |
| reg_rdata | output | 16 | Current register contents |
| cap_a | input | 1 | Channel A capture event strobe |
| cap_b | input | 1 | Channel B capture event strobe |
| cmp_a | input | 1 | Channel A compare match strobe |
| cmp_b | input | 1 | Channel B compare match strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the interlocked clear, where a wrong design behaves in one of several ways. One clears on any write of 0. Another keeps the arm alive across an intervening event and loses that event. A third lets a clear beat a same-cycle set, so an event goes unreported. The period-measurement mode is probed by sending one capture, then two, then re-writing the same mode. A design that never suppresses, suppresses every capture, or re-arms on an unchanged mode would raise or miss the flag on the wrong capture. Each mode is also given the strobes it must ignore, which catches channel or compare/capture swaps in the decode. Finally, the bench checks the spare modes and the clear-on-off behaviour.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  localparam int REG_W    = 16;
  localparam int FLAG_BIT = 15;
  localparam int LVL_LSB  = 12;
  localparam int LVL_W    = 3;
  localparam int AUX_LSB  = 5;
  localparam int AUX_W    = 7;
  localparam int MODE_W   = 4;
  localparam int LVL_MSB  = LVL_LSB + LVL_W - 1;
  localparam int AUX_MSB  = AUX_LSB + AUX_W - 1;

  typedef enum logic [2:0] {
    OP_OFF, OP_IPW, OP_IPM, OP_ICAP, OP_OCB, OP_OCAB, OP_OPWM, OP_SPARE
  } op_e;

  typedef struct packed {
    logic cap_a;
    logic cap_b;
    logic cmp_a;
    logic cmp_b;
  } strobe_t;

  function automatic op_e decode_mode(input logic [MODE_W-1:0] m);
    op_e r;
    casez (m)
      4'b0000: r = OP_OFF;
      4'b0001: r = OP_IPW;
      4'b0010: r = OP_IPM;
      4'b0011: r = OP_ICAP;
      4'b0100: r = OP_OCB;
      4'b0101: r = OP_OCAB;
      4'b1???: r = OP_OPWM;
      default: r = OP_SPARE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ccf_event_sel.sv
module ccf_event_sel
  import ccf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  op_e     op,
  input  logic    mode_chg,
  input  strobe_t stb,
  output logic    set_ev
);
  // Pending-first-capture marker for period measurement.
  logic first_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      first_pend_q <= 1'b1;
    else if (mode_chg)
      first_pend_q <= 1'b1;
    else if (op == OP_IPM && stb.cap_a)
      first_pend_q <= 1'b0;
  end

  always_comb begin
    unique case (op)
      OP_IPW, OP_ICAP: set_ev = stb.cap_a;
      OP_IPM:          set_ev = stb.cap_a & ~first_pend_q;
      OP_OCB:          set_ev = stb.cmp_b;
      OP_OCAB:         set_ev = stb.cmp_a | stb.cmp_b;
      OP_OPWM:         set_ev = stb.cmp_a;
      default:         set_ev = 1'b0;
    endcase
  end
endmodule

// File: rtl/ccf_clear_arm.sv
module ccf_clear_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic rd,
  input  logic wr,
  input  logic wr_flag_bit,
  input  logic flag_q,
  input  logic set_ev,
  output logic clr_ok
);
  logic arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      arm_q <= 1'b0;
    else if (set_ev || wr)
      arm_q <= 1'b0;
    else if (rd && flag_q)
      arm_q <= 1'b1;
  end

  assign clr_ok = wr && !wr_flag_bit && arm_q && !set_ev;
endmodule

// File: rtl/ccf_reg.sv
module ccf_reg
  import ccf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              cap_a,
  input  logic              cap_b,
  input  logic              cmp_a,
  input  logic              cmp_b,
  output logic              irq
);
  logic              flag_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [AUX_W-1:0]  aux_q;
  logic [MODE_W-1:0] mode_q;
  logic              set_ev, clr_ok, mode_chg, wr_off;
  logic [MODE_W-1:0] wr_mode;
  op_e               op;
  strobe_t           stb;
  logic              unused_wbit;

  assign unused_wbit = reg_wdata[AUX_LSB-1];
  assign wr_mode  = reg_wdata[MODE_W-1:0];
  assign mode_chg = reg_wr && (wr_mode != mode_q);
  assign wr_off   = reg_wr && (decode_mode(wr_mode) == OP_OFF);
  assign op       = decode_mode(mode_q);
  assign stb      = '{cap_a: cap_a, cap_b: cap_b, cmp_a: cmp_a, cmp_b: cmp_b};

  ccf_event_sel u_sel (
    .clk(clk), .rst_n(rst_n), .op(op), .mode_chg(mode_chg),
    .stb(stb), .set_ev(set_ev)
  );

  ccf_clear_arm u_arm (
    .clk(clk), .rst_n(rst_n), .rd(reg_rd), .wr(reg_wr),
    .wr_flag_bit(reg_wdata[FLAG_BIT]), .flag_q(flag_q),
    .set_ev(set_ev), .clr_ok(clr_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      aux_q  <= '0;
      mode_q <= '0;
    end else if (reg_wr) begin
      lvl_q  <= reg_wdata[LVL_MSB:LVL_LSB];
      aux_q  <= reg_wdata[AUX_MSB:AUX_LSB];
      mode_q <= wr_mode;
    end
  end

  // Priority: off mode, then set event, then interlocked clear.
  always_ff @(posedge clk) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (op == OP_OFF || wr_off)
      flag_q <= 1'b0;
    else if (set_ev)
      flag_q <= 1'b1;
    else if (clr_ok)
      flag_q <= 1'b0;
  end

  assign reg_rdata = {flag_q, lvl_q, aux_q, 1'b0, mode_q};
  assign irq       = flag_q && (lvl_q != '0);
endmodule

// File: rtl/ccf_reg_chk.sv
module ccf_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic        cap_a,
  input logic        cap_b,
  input logic        cmp_a,
  input logic        cmp_b,
  input logic        irq,
  input logic        set_ev
);
  a_r3_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15] && (reg_rdata[14:12] != 3'd0)) |-> irq);
  a_r3_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rdata[15] && (reg_rdata[14:12] != 3'd0)) |-> !irq);
  a_r2_spare_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[4]);
  a_r4_off_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[3:0] == 4'd0) |-> !reg_rdata[15]);
  a_r10_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[15]) |-> $past(cap_a || cap_b || cmp_a || cmp_b));
  a_r11_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[15]) |-> $past(reg_wr));
  a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev && !(reg_wr && reg_wdata[3:0] == 4'd0)) |=> reg_rdata[15]);
endmodule

bind ccf_reg ccf_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .cap_a(cap_a), .cap_b(cap_b), .cmp_a(cmp_a),
  .cmp_b(cmp_b), .irq(irq), .set_ev(set_ev)
);

// File: tb/sim_ccf_reg.sv
module sim_ccf_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // Vector: {req[3:0], mode[3:0], strobes capA,capB,cmpA,cmpB [3:0], pulses[1:0], expected flag}
  localparam logic [14:0] VEC [NVEC] = '{
    {4'd5,  4'b0001, 4'b1000, 2'd1, 1'b1},  // R5 capture A sets
    {4'd5,  4'b0001, 4'b0111, 2'd1, 1'b0},  // R5 others ignored
    {4'd5,  4'b0011, 4'b1000, 2'd1, 1'b1},  // R5
    {4'd5,  4'b0011, 4'b0010, 2'd1, 1'b0},  // R5
    {4'd6,  4'b0010, 4'b1000, 2'd1, 1'b0},  // R6 first ignored
    {4'd6,  4'b0010, 4'b1000, 2'd2, 1'b1},  // R6 second sets
    {4'd7,  4'b0100, 4'b0010, 2'd1, 1'b0},  // R7 B only
    {4'd7,  4'b0100, 4'b0001, 2'd1, 1'b1},  // R7
    {4'd7,  4'b0101, 4'b0010, 2'd1, 1'b1},  // R7 A or B
    {4'd7,  4'b0101, 4'b0001, 2'd1, 1'b1},  // R7
    {4'd8,  4'b1000, 4'b0010, 2'd1, 1'b1},  // R8
    {4'd8,  4'b1110, 4'b1101, 2'd1, 1'b0},  // R8 others ignored
    {4'd9,  4'b0110, 4'b1111, 2'd1, 1'b0},  // R9 spare
    {4'd4,  4'b0000, 4'b1111, 2'd1, 1'b0}   // R4 off
  };

  logic clk = 1'b0, rst_n = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic cap_a = 1'b0, cap_b = 1'b0, cmp_a = 1'b0, cmp_b = 1'b0, irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccf_reg u0 (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] s);
    @(negedge clk); {cap_a, cap_b, cmp_a, cmp_b} = s;
    @(negedge clk); {cap_a, cap_b, cmp_a, cmp_b} = 4'b0000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset word", reg_rdata, 16'h0000);
    check("R1 reset irq", {15'd0, irq}, 16'd0);

    for (int i = 0; i < NVEC; i++) begin
      wr(16'h0000);
      wr({12'd0, VEC[i][10:7]});
      for (int p = 0; p < int'(VEC[i][2:1]); p++) pulse(VEC[i][6:3]);
      check($sformatf("R%0d vector %0d flag", VEC[i][14:11], i),
            {15'd0, reg_rdata[15]}, {15'd0, VEC[i][0]});
    end

    // R2 field layout and storage
    wr(16'h0000);
    wr(16'h7FF3);
    check("R2 layout", reg_rdata, 16'h7FE3);
    wr(16'h0003);

    // R10 writing 1 to flag bit
    wr(16'h8003);
    check("R10 write one", {15'd0, reg_rdata[15]}, 16'd0);

    // R11 write without read keeps flag
    pulse(4'b1000);
    wr(16'h0003);
    check("R11 unarmed write", {15'd0, reg_rdata[15]}, 16'd1);
    // R11 any write disarms
    rd(); wr(16'h8003); wr(16'h0003);
    check("R11 disarm", {15'd0, reg_rdata[15]}, 16'd1);
    // R11 proper clear
    rd(); wr(16'h0003);
    check("R11 clear", {15'd0, reg_rdata[15]}, 16'd0);

    // R12 intervening set cancels clear
    pulse(4'b1000); rd(); pulse(4'b1000); wr(16'h0003);
    check("R12 intervening event", {15'd0, reg_rdata[15]}, 16'd1);

    // R13 same-cycle set and clearing write
    rd();
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 16'h0003; cap_a = 1'b1;
    @(negedge clk); reg_wr = 1'b0; cap_a = 1'b0;
    check("R13 set wins", {15'd0, reg_rdata[15]}, 16'd1);

    // R3 interrupt level
    wr(16'h3003);
    check("R3 irq high", {15'd0, irq}, 16'd1);
    wr(16'h0003);
    check("R3 irq level zero", {15'd0, irq}, 16'd0);
    rd(); wr(16'h5003);
    check("R3 irq flag clear", {15'd0, irq}, 16'd0);

    // R4 write of off mode clears flag
    pulse(4'b1000);
    wr(16'h0000);
    check("R4 off clears", reg_rdata, 16'h0000);

    // R6 rewriting same mode does not re-arm suppression
    wr(16'h0002); pulse(4'b1000); wr(16'h0002); pulse(4'b1000);
    check("R6 same mode rewrite", {15'd0, reg_rdata[15]}, 16'd1);

    // R9 spare mode holds a set flag
    wr(16'h0006); pulse(4'b1111);
    check("R9 spare holds", {15'd0, reg_rdata[15]}, 16'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule